// File: doc/BRIEF.md
# Multicontext Four-Input Lookup Cell

This block is a single fine-grained logic cell for an array that switches its whole configuration from one clock cycle to the next. The cell keeps four complete configurations on chip. A 2-bit context number, driven in common to every cell of the array, picks which configuration is live in the current cycle. Each configuration gives a 16-entry truth table for a four-input lookup table. It also gives four selectors that route four of eight local candidate signals onto the table's address lines, and one flag that chooses between the combinational table result and the registered one.

The cell has exactly one state element, a one-bit output register. It samples the lookup result on every rising clock edge, at the same moment that the next context becomes active. A context whose registered-output flag is set therefore presents the value that the preceding context computed. This is the only way a value can pass from one context to the next. A configuration write port loads one 32-bit word into one chosen context, and the other contexts are left unchanged. Storage is ordinary flip-flops. Reset is asynchronous and active-low, and its release is synchronised inside the cell.

Top module: `mctx_lut_cell`

## Requirements
- R1: The lookup result is bit `idx` of the active truth table (word bits 15:0), where `idx` = {a3,a2,a1,a0} and a0 is the least significant address bit.
- R2: Address line ak is `cand[s]`, where s is the 3-bit selector held in word bits 16+3k+2 down to 16+3k (k = 0..3).
- R3: `ctx_id` selects the active configuration combinationally, and it may take a different value on every cycle.
- R4: On every rising clock edge outside reset, the output register loads the lookup result of the context that was active just before that edge.
- R5: When bit 28 of the active word is 1, `cell_out` is the output register. When it is 0, `cell_out` is the combinational lookup result.
- R6: With `cfg_we` high, `cfg_word` is stored into context `cfg_ctx` at the next rising edge. Before that edge the old word still applies, and every other context is left unchanged.
- R7: While reset is applied, and after it is released until the first write, the output register is 0 and every context gives a constant-zero combinational output.
- R8: Word bits 31:29 are reserved. Their value has no effect on `cell_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised internally |
| ctx_id | input | 2 | Active context number, shared across the array |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ctx | input | 2 | Context that a write targets |
| cfg_word | input | 32 | Configuration word to write |
| cand | input | 8 | Local candidate signals for the LUT inputs |
| cell_out | output | 1 | Cell output |

## Verification
The bench sweeps all 256 candidate patterns through contexts that use identity selectors and through contexts that use permuted selectors. A cell that reversed the address bit order or misplaced a selector field would fail these sweeps. It alternates a combinational context with a registered one on every cycle. A design that latched the value after the context switch, or that held the register instead of reloading it each edge, would replay the wrong value. It also checks that a write takes effect only at its edge and only in its own context, that set reserved bits change nothing, and that the output is zero during reset and straight after it.

// File: rtl/mctx_pkg.sv
package mctx_pkg;
  localparam int LUT_K   = 4;
  localparam int TT_W    = 1 << LUT_K;
  localparam int CAND_N  = 8;
  localparam int SEL_W   = $clog2(CAND_N);
  localparam int WORD_W  = 32;
  localparam int CFG_W   = TT_W + LUT_K * SEL_W + 1;
  localparam int CTX_N   = 4;
  localparam int CTX_W   = $clog2(CTX_N);

  typedef struct packed {
    logic                         reg_mode;
    logic [LUT_K-1:0][SEL_W-1:0]  sel;
    logic [TT_W-1:0]              tt;
  } cell_cfg_t;
endpackage

// File: rtl/mctx_rst_sync.sv
module mctx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/mctx_cfg_store.sv
module mctx_cfg_store
  import mctx_pkg::*;
#(
  parameter int N_CTX = CTX_N,
  localparam int CW   = $clog2(N_CTX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CW-1:0]     wr_ctx,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [CW-1:0]     rd_ctx,
  output cell_cfg_t         rd_cfg
);
  cell_cfg_t store_q [N_CTX];
  cell_cfg_t new_cfg;
  logic      unused_rsvd;

  // reserved high bits are dropped on the way in (R8)
  assign new_cfg     = cell_cfg_t'(wr_word[CFG_W-1:0]);
  assign unused_rsvd = ^wr_word[WORD_W-1:CFG_W];

  for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
    logic      load_en;
    cell_cfg_t slot_d;

    always_comb begin
      load_en = wr_en && (wr_ctx == CW'(c));
      slot_d  = load_en ? new_cfg : store_q[c];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) store_q[c] <= '0;
      else        store_q[c] <= slot_d;
    end

    a_r6_other_ctx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_ctx == CW'(c)) |=> $stable(store_q[c]));
  end

  assign rd_cfg = store_q[rd_ctx];
endmodule

// File: rtl/mctx_lut_eval.sv
module mctx_lut_eval
  import mctx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  cell_cfg_t         cfg,
  input  logic [CAND_N-1:0] cand,
  output logic              y
);
  logic [LUT_K-1:0] addr;

  for (genvar k = 0; k < LUT_K; k++) begin : g_pin
    assign addr[k] = cand[cfg.sel[k]];
  end

  assign y = cfg.tt[addr];

  a_r1_full_table_one: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.tt == '1) |-> y);
  a_r1_empty_table_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.tt == '0) |-> !y);
endmodule

// File: rtl/mctx_lut_cell.sv
module mctx_lut_cell
  import mctx_pkg::*;
#(
  parameter int N_CTX = CTX_N,
  localparam int CW   = $clog2(N_CTX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     ctx_id,
  input  logic              cfg_we,
  input  logic [CW-1:0]     cfg_ctx,
  input  logic [WORD_W-1:0] cfg_word,
  input  logic [CAND_N-1:0] cand,
  output logic              cell_out
);
  logic      rst_q_n;
  cell_cfg_t act_cfg;
  logic      lut_y;
  logic      out_d, out_q;
  logic      seen_q;

  mctx_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_q_n)
  );

  mctx_cfg_store #(.N_CTX(N_CTX)) u_store (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .wr_en   (cfg_we),
    .wr_ctx  (cfg_ctx),
    .wr_word (cfg_word),
    .rd_ctx  (ctx_id),
    .rd_cfg  (act_cfg)
  );

  mctx_lut_eval u_eval (
    .clk   (clk),
    .rst_n (rst_q_n),
    .cfg   (act_cfg),
    .cand  (cand),
    .y     (lut_y)
  );

  // output register samples every edge: the only inter-context path
  always_comb out_d = lut_y;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) out_q <= 1'b0;
    else          out_q <= out_d;
  end

  assign cell_out = act_cfg.reg_mode ? out_q : lut_y;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) seen_q <= 1'b0;
    else          seen_q <= 1'b1;
  end

  a_r4_replay_prev_ctx: assert property (@(posedge clk) disable iff (!rst_q_n)
    (seen_q && act_cfg.reg_mode) |-> (cell_out == $past(lut_y)));
  a_r7_zero_after_reset: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(rst_q_n) |-> (out_q == 1'b0 && cell_out == 1'b0));
endmodule

// File: tb/sim_mctx_lut_cell.sv
module sim_mctx_lut_cell;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  ctx_id;
  logic        cfg_we;
  logic [1:0]  cfg_ctx;
  logic [31:0] cfg_word;
  logic [7:0]  cand;
  logic        cell_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  mctx_lut_cell u0 (
    .clk(clk), .rst_n(rst_n), .ctx_id(ctx_id), .cfg_we(cfg_we),
    .cfg_ctx(cfg_ctx), .cfg_word(cfg_word), .cand(cand), .cell_out(cell_out)
  );

  // word: tt[15:0], sel k at [16+3k +: 3], reg flag [28], reserved [31:29]
  function automatic logic ref_lut(logic [31:0] w, logic [7:0] c);
    logic [3:0] a;
    for (int k = 0; k < 4; k++) a[k] = c[w[16+3*k +: 3]];
    return w[a];
  endfunction

  function automatic logic [31:0] mk(logic [15:0] tt, logic [2:0] s0,
      logic [2:0] s1, logic [2:0] s2, logic [2:0] s3, logic rm);
    return {3'b000, rm, s3, s2, s1, s0, tt};
  endfunction

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(logic [1:0] c, logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ctx = c; cfg_word = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  logic [31:0] w0, w1, w1b, w3;

  initial begin
    rst_n = 1'b0; ctx_id = '0; cfg_we = 1'b0; cfg_ctx = '0; cfg_word = '0; cand = '0;
    w0  = mk(16'hB3C5, 3'd0, 3'd1, 3'd2, 3'd3, 1'b0);
    w1  = mk(16'h7E18, 3'd7, 3'd5, 3'd2, 3'd6, 1'b0);
    w1b = mk(16'h1234, 3'd4, 3'd0, 3'd3, 3'd1, 1'b0);
    w3  = mk(16'h96A3, 3'd6, 3'd4, 3'd1, 3'd7, 1'b1);

    // R7: zero while in reset, even with a write strobe present
    cfg_we = 1'b1; cfg_word = 32'hFFFF_FFFF;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      ctx_id = i[1:0]; cfg_ctx = i[1:0]; cand = 8'(i * 37);
      #1 chk("R7 in reset", cell_out, 1'b0);
    end
    cfg_we = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R7: after release all contexts are constant zero
    for (int c = 0; c < 4; c++)
      for (int v = 0; v < 256; v += 17) begin
        ctx_id = c[1:0]; cand = v[7:0];
        #1 chk("R7 post-reset", cell_out, 1'b0);
      end

    wr(2'd0, w0);
    wr(2'd1, w1);
    wr(2'd2, w0 | 32'hE000_0000);
    wr(2'd3, w3);

    // R1 identity selectors, R2 permuted selectors, R8 reserved bits
    for (int v = 0; v < 256; v++) begin
      cand = v[7:0];
      ctx_id = 2'd0; #1 chk("R1 sweep", cell_out, ref_lut(w0, v[7:0]));
      ctx_id = 2'd1; #1 chk("R2 sweep", cell_out, ref_lut(w1, v[7:0]));
      ctx_id = 2'd2; #1 chk("R8 reserved", cell_out, ref_lut(w0, v[7:0]));
    end

    // R3/R4/R5: alternate comb context and registered context each cycle
    for (int v = 0; v < 256; v++) begin
      @(negedge clk);
      ctx_id = 2'd0; cand = v[7:0];
      #1 chk("R3 comb ctx", cell_out, ref_lut(w0, v[7:0]));
      @(posedge clk); #2;
      ctx_id = 2'd3; cand = ~v[7:0];
      @(negedge clk);
      chk("R4 replay prev ctx", cell_out, ref_lut(w0, v[7:0]));
      @(posedge clk); #2;
      cand = v[7:0] ^ 8'h5A;
      @(negedge clk);
      chk("R5 reg mode own ctx", cell_out, ref_lut(w3, ~v[7:0]));
    end

    // R6: write applies only at its edge, only to its own context
    @(negedge clk);
    ctx_id = 2'd1; cand = 8'hC6;
    cfg_we = 1'b1; cfg_ctx = 2'd1; cfg_word = w1b;
    #1 chk("R6 before edge", cell_out, ref_lut(w1, 8'hC6));
    @(posedge clk); #1;
    chk("R6 after edge", cell_out, ref_lut(w1b, 8'hC6));
    @(negedge clk); cfg_we = 1'b0;
    for (int v = 0; v < 256; v += 3) begin
      cand = v[7:0];
      ctx_id = 2'd0; #1 chk("R6 ctx0 kept", cell_out, ref_lut(w0, v[7:0]));
      ctx_id = 2'd2; #1 chk("R6 ctx2 kept", cell_out, ref_lut(w0, v[7:0]));
      ctx_id = 2'd1; #1 chk("R6 ctx1 new", cell_out, ref_lut(w1b, v[7:0]));
    end

    // R7: asynchronous reset mid-run
    @(negedge clk);
    ctx_id = 2'd0; cand = 8'hFF;
    rst_n = 1'b0;
    #1 chk("R7 async reset", cell_out, 1'b0);
    ctx_id = 2'd3;
    #1 chk("R7 async reset reg", cell_out, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule